// File: doc/BRIEF.md
# Mixed-Basis Tower-Field Byte Inverter

This block returns the multiplicative inverse of an 8-bit element of GF(2^8). The field is built as a tower: GF(4) over GF(2), GF(16) over GF(4), then GF(256) over GF(16). The output depends on the current input alone. The block has no clock and no storage. It sits between the basis-change matrices of a byte substitution stage, and those matrices are outside this block. The input arrives in a normal basis over GF(16) and the inverse leaves in a polynomial basis.

Internally the block computes a GF(16) norm of the input, inverts that norm, and scales the two input coordinates by the result. Each GF(16) operator uses whichever representation keeps the path short. The square-and-scale unit and the mixed multiplier produce normal-basis results. These results add directly into the normal-basis GF(16) inverter. That inverter hands a polynomial-basis value to two general multipliers.

Top module: `gf256_mixed_inv`

## Requirements
- R1: Encoding. GF(4) is defined by α^2 = α + 1, and a 2-bit GF(4) value holds the coefficient of α in bit 0 and the coefficient of α^2 in bit 1. GF(16) is defined by β^2 = β + α, and a 4-bit polynomial value holds the constant in bits [1:0] and the β coefficient in bits [3:2]. GF(256) is defined by γ^2 = γ + ν with ν = α·β, which is 4'b0100. x_in[3:0] is the coefficient of γ and x_in[7:4] is the coefficient of γ^16, both in GF(16) polynomial form. The field's unit element is therefore x_in = 8'h33, and its inverse is y_out = 8'h03.
- R2: y_out is in polynomial form. y_out[3:0] is the constant coefficient and y_out[7:4] is the γ coefficient. For every nonzero x_in, the field product of x_in and y_out equals one (8'h03).
- R3: An input of zero gives an output of zero.
- R4: Every nonzero input gives a nonzero output. Over the 255 nonzero inputs, the outputs are all distinct.
- R5: Rewrite y_out in normal form as ({b0}, {b0^b1}), where b0 = y_out[3:0] and b1 = y_out[7:4]. Feeding this back gives the original input, expressed in polynomial form as {x[3:0]^x[7:4], x[7:4]}.
- R6: For a nonzero input, y_out[3:0] is zero exactly when x_in[3:0] is zero.
- R7: For a nonzero input, y_out[7:4] is zero exactly when x_in[3:0] equals x_in[7:4].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 8 | Element to invert, normal basis over GF(16) |
| y_out | output | 8 | Inverse, polynomial basis over GF(16) |

## Verification
The bench applies all 256 input values. For each result it multiplies input by output in its own schoolbook tower model, which builds GF(4) on discrete logarithms. This separates a correct inverse from one with a swapped basis, a wrong tower constant or a bad sub-operator. A second sweep feeds each result back after a change of basis. This exposes errors that keep the product at one for some inputs but break the pairing between inputs and outputs. The zero input, the unit element 8'h33, and inputs with one GF(16) coordinate zero or with equal coordinates pin down the boundary cases of R3, R6 and R7.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;

  localparam int GF4_W   = 2;
  localparam int GF16_W  = 2 * GF4_W;
  localparam int GF256_W = 2 * GF16_W;

  typedef logic [GF4_W-1:0]   gf4_t;
  typedef logic [GF16_W-1:0]  gf16_t;
  typedef logic [GF256_W-1:0] gf256_t;

  // GF(4) product, both operands and result in normal form {a^2, a}
  function automatic gf4_t gf4_mul(input gf4_t a, input gf4_t b);
    logic t;
    t = (a[0] ^ a[1]) & (b[0] ^ b[1]);
    return {t ^ (a[1] & b[1]), t ^ (a[0] & b[0])};
  endfunction

  // Frobenius in normal form is a swap; for GF(4) it is also the inverse
  function automatic gf4_t gf4_sq(input gf4_t a);
    return {a[0], a[1]};
  endfunction

  // Multiply by alpha (the GF(16) tower constant)
  function automatic gf4_t gf4_mul_al(input gf4_t a);
    return {a[0] ^ a[1], a[1]};
  endfunction

  // Multiply by alpha^2
  function automatic gf4_t gf4_mul_al2(input gf4_t a);
    return {a[0], a[0] ^ a[1]};
  endfunction

  // Normal {beta, beta^4} to polynomial {1, beta}
  function automatic gf16_t gf16_n2p(input gf16_t n);
    return {n[1:0] ^ n[3:2], n[3:2]};
  endfunction

  // Square and scale by nu = alpha*beta: polynomial in, normal out
  function automatic gf16_t gf16_sq_nu(input gf16_t a);
    gf4_t p0, p1, r0, r1;
    p1 = gf4_sq(a[3:2]);
    p0 = gf4_sq(a[1:0]) ^ gf4_mul_al(p1);
    r0 = gf4_mul_al2(p1);
    r1 = gf4_mul_al(p0 ^ p1);
    return {r0, r0 ^ r1};
  endfunction

  // GF(16) inverse: normal in, polynomial out
  function automatic gf16_t gf16_inv(input gf16_t n);
    gf4_t s, nrm, ninv;
    s    = n[1:0] ^ n[3:2];
    nrm  = gf4_mul_al(gf4_sq(s)) ^ gf4_mul(n[1:0], n[3:2]);
    ninv = gf4_sq(nrm);
    return {gf4_mul(ninv, s), gf4_mul(ninv, n[1:0])};
  endfunction

  // General GF(16) product in polynomial form
  function automatic gf16_t gf16_mul_p(input gf16_t a, input gf16_t b);
    gf4_t ll, hh, mm;
    ll = gf4_mul(a[1:0], b[1:0]);
    hh = gf4_mul(a[3:2], b[3:2]);
    mm = gf4_mul(a[1:0] ^ a[3:2], b[1:0] ^ b[3:2]);
    return {mm ^ ll, ll ^ gf4_mul_al(hh)};
  endfunction

endpackage

// File: rtl/gf16_sq_nu.sv
module gf16_sq_nu
  import gf_tower_pkg::*;
(
  input  logic [GF16_W-1:0] a_i,
  output logic [GF16_W-1:0] n_o
);
  assign n_o = gf16_sq_nu(a_i);
endmodule

// File: rtl/gf16_inv_n2p.sv
module gf16_inv_n2p
  import gf_tower_pkg::*;
(
  input  logic [GF16_W-1:0] n_i,
  output logic [GF16_W-1:0] p_o
);
  assign p_o = gf16_inv(n_i);
endmodule

// File: rtl/gf16_mul.sv
module gf16_mul
  import gf_tower_pkg::*;
#(
  parameter bit OUT_NORMAL = 1'b0
) (
  input  logic [GF16_W-1:0] a_i,
  input  logic [GF16_W-1:0] b_i,
  output logic [GF16_W-1:0] c_o
);
  gf4_t ll_w, hh_w, mm_w, hs_w;

  assign ll_w = gf4_mul(a_i[1:0], b_i[1:0]);
  assign hh_w = gf4_mul(a_i[3:2], b_i[3:2]);
  assign mm_w = gf4_mul(a_i[1:0] ^ a_i[3:2], b_i[1:0] ^ b_i[3:2]);
  assign hs_w = gf4_mul_al(hh_w);

  generate
    if (OUT_NORMAL) begin : g_normal
      // beta coefficient, beta^4 coefficient
      assign c_o = {ll_w ^ hs_w, mm_w ^ hs_w};
    end else begin : g_poly
      assign c_o = {mm_w ^ ll_w, ll_w ^ hs_w};
    end
  endgenerate
endmodule

// File: rtl/gf256_mixed_inv.sv
module gf256_mixed_inv
  import gf_tower_pkg::*;
(
  input  logic [7:0] x_in,
  output logic [7:0] y_out
);
  gf16_t al_w, ah_w, sum_w, sqnu_w, cross_w, norm_w, ninv_w, lo_w, hi_w;

  assign al_w  = x_in[GF16_W-1:0];
  assign ah_w  = x_in[GF256_W-1:GF16_W];
  assign sum_w = al_w ^ ah_w;

  gf16_sq_nu u_sqnu (.a_i(sum_w), .n_o(sqnu_w));

  gf16_mul #(.OUT_NORMAL(1'b1)) u_mul_cross (
    .a_i(al_w), .b_i(ah_w), .c_o(cross_w)
  );

  assign norm_w = sqnu_w ^ cross_w;

  gf16_inv_n2p u_inv (.n_i(norm_w), .p_o(ninv_w));

  gf16_mul #(.OUT_NORMAL(1'b0)) u_mul_lo (
    .a_i(ninv_w), .b_i(al_w), .c_o(lo_w)
  );

  gf16_mul #(.OUT_NORMAL(1'b0)) u_mul_hi (
    .a_i(ninv_w), .b_i(sum_w), .c_o(hi_w)
  );

  assign y_out = {hi_w, lo_w};
endmodule

// File: rtl/gf256_mixed_inv_chk.sv
module gf256_mixed_inv_chk
  import gf_tower_pkg::*;
(
  input logic [7:0] x_in,
  input logic [7:0] y_out,
  input logic [3:0] norm_w,
  input logic [3:0] ninv_w
);
  always_comb begin
    if (!$isunknown(x_in)) begin
      // R3
      zero_maps_zero_chk: assert ((x_in != 8'h00) || (y_out == 8'h00))
        else $error("zero input gave %h", y_out);
      // R4
      nonzero_out_chk: assert ((x_in == 8'h00) || (y_out != 8'h00))
        else $error("nonzero input %h gave zero", x_in);
      // R4
      norm_nonzero_chk: assert ((x_in == 8'h00) == (norm_w == 4'h0))
        else $error("norm %h for input %h", norm_w, x_in);
      // R2
      norm_inverse_chk: assert ((norm_w == 4'h0) ||
                                (gf16_mul_p(gf16_n2p(norm_w), ninv_w) == 4'h3))
        else $error("norm %h inverse %h", norm_w, ninv_w);
      // R6
      lo_zero_chk: assert ((x_in == 8'h00) ||
                           ((y_out[3:0] == 4'h0) == (x_in[3:0] == 4'h0)))
        else $error("low coordinate mismatch %h -> %h", x_in, y_out);
      // R7
      hi_zero_chk: assert ((x_in == 8'h00) ||
                           ((y_out[7:4] == 4'h0) == (x_in[3:0] == x_in[7:4])))
        else $error("high coordinate mismatch %h -> %h", x_in, y_out);
    end
  end
endmodule

bind gf256_mixed_inv gf256_mixed_inv_chk u_chk (
  .x_in(x_in), .y_out(y_out), .norm_w(norm_w), .ninv_w(ninv_w)
);

// File: tb/gf256_mixed_inv_tb.sv
module gf256_mixed_inv_tb;
  logic       clk = 1'b0;
  logic [7:0] x_in = 8'h00;
  logic [7:0] y_out;
  int         total = 0;
  int         bad = 0;
  int         cycles = 0;
  bit         done = 1'b0;
  logic [7:0] inv_tab [256];
  bit         seen [256];

  always #10 clk = ~clk;

  gf256_mixed_inv u_dut (.x_in(x_in), .y_out(y_out));

  // GF(4) via discrete logarithms: 01 -> alpha^1, 10 -> alpha^2, 11 -> alpha^0
  function automatic int lg4(input logic [1:0] a);
    return (a == 2'b01) ? 1 : (a == 2'b10) ? 2 : 0;
  endfunction
  function automatic logic [1:0] ex4(input int e);
    return (e == 1) ? 2'b01 : (e == 2) ? 2'b10 : 2'b11;
  endfunction
  function automatic logic [1:0] m4(input logic [1:0] a, input logic [1:0] b);
    if (a == 2'b00 || b == 2'b00) return 2'b00;
    return ex4((lg4(a) + lg4(b)) % 3);
  endfunction
  // GF(16) schoolbook, beta^2 = beta + alpha
  function automatic logic [3:0] m16(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] c0, c1;
    c0 = m4(a[1:0], b[1:0]) ^ m4(2'b01, m4(a[3:2], b[3:2]));
    c1 = m4(a[1:0], b[3:2]) ^ m4(a[3:2], b[1:0]) ^ m4(a[3:2], b[3:2]);
    return {c1, c0};
  endfunction
  // GF(256) schoolbook in polynomial form, gamma^2 = gamma + nu, nu = 4'b0100
  function automatic logic [7:0] m256(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] c0, c1;
    c0 = m16(a[3:0], b[3:0]) ^ m16(4'b0100, m16(a[7:4], b[7:4]));
    c1 = m16(a[3:0], b[7:4]) ^ m16(a[7:4], b[3:0]) ^ m16(a[7:4], b[7:4]);
    return {c1, c0};
  endfunction
  // normal-form byte {coef gamma^16, coef gamma} to polynomial form
  function automatic logic [7:0] n2p(input logic [7:0] n);
    return {n[3:0] ^ n[7:4], n[7:4]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s x=%h actual=%h expected=%h", req, x_in, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    @(negedge clk);
    x_in = v;
    #2;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int dups;
    repeat (3) @(posedge clk);

    // R3: zero in, zero out (rest state of the block)
    apply(8'h00);
    check(y_out == 8'h00, "R3", y_out, 8'h00);

    // R1: unit element in normal form maps to unit in polynomial form
    apply(8'h33);
    check(y_out == 8'h03, "R1", y_out, 8'h03);

    // R2, R6, R7 over every nonzero input
    for (int v = 1; v < 256; v++) begin
      apply(v[7:0]);
      inv_tab[v] = y_out;
      check(m256(n2p(v[7:0]), y_out) == 8'h03, "R2",
            m256(n2p(v[7:0]), y_out), 8'h03);
      check((y_out[3:0] == 4'h0) == (v[3:0] == 4'h0), "R6", y_out, 8'h00);
      check((y_out[7:4] == 4'h0) == (v[3:0] == v[7:4]), "R7", y_out, 8'h00);
    end

    // R4: nonzero and distinct
    dups = 0;
    for (int v = 0; v < 256; v++) seen[v] = 1'b0;
    for (int v = 1; v < 256; v++) begin
      if (inv_tab[v] == 8'h00 || seen[inv_tab[v]]) dups++;
      seen[inv_tab[v]] = 1'b1;
    end
    check(dups == 0, "R4", dups[7:0], 8'h00);

    // R5: inverse of the inverse, after rewriting the result in normal form
    for (int v = 1; v < 256; v++) begin
      logic [7:0] b;
      b = inv_tab[v];
      apply({b[3:0], b[3:0] ^ b[7:4]});
      check(y_out == n2p(v[7:0]), "R5", y_out, n2p(v[7:0]));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule